// File: doc/BRIEF.md
# Key-Sequence Write Lock

This block keeps a group of configuration registers (time, date, control, prescaler and alarm settings) from being changed by stray bus writes. Software opens the lock by writing two byte-wide key values, one after the other, to a dedicated key register. Any other write to that register closes the lock again. The bus decoder supplies a write strobe, a select line that is high when the key register is addressed, and the write byte. Each protected register supplies its own write request. The block passes a request through only while the lock is open.

A write that is refused is simply lost. No error is raised, and the register keeps its old contents. The lock state lives in a flop, so a key write changes the gating from the clock cycle that follows it.

Top module: `keyLock`

## Requirements
- R1: After reset the lock is closed. `unlocked` is 0 and every `protWrEn` lane is 0.
- R2: A key write of 0xCA followed by a key write of 0x53 opens the lock. `unlocked` reads 1 from the cycle after the 0x53 write.
- R3: After a 0xCA key write, a next key write of any value other than 0x53 closes the lock and discards the 0xCA. This includes a second 0xCA.
- R4: While the lock is open, any key write closes it, whatever the value (0xFF, 0xCA and 0x53 included). A 0xCA written while open does not begin a new sequence.
- R5: While the lock is closed, every `protWrEn` lane is 0 whatever `protWrReq` is. No error indication exists.
- R6: While the lock is open, each `protWrEn` lane equals its `protWrReq` lane.
- R7: A key write counts only when `keyWrStrobe` and `keySel` are both 1 in the same cycle. Any other cycle leaves the lock state unchanged.
- R8: From the closed state, a 0x53 key write, or any value other than 0xCA, keeps the lock closed. A lone 0xCA does not open it.
- R9: A protected write request in the same cycle as the 0x53 key write that opens the lock is refused.
- R10: Cycles with no key write between the 0xCA and the 0x53 writes do not break the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| keyWrStrobe | input | 1 | Bus write strobe |
| keySel | input | 1 | Address match for the key register |
| keyData | input | DATA_W | Byte written to the key register |
| protWrReq | input | NUM_PROT | Write requests from the protected registers |
| protWrEn | output | NUM_PROT | Qualified write enables for the protected registers |
| unlocked | output | 1 | Lock is open |

## Verification
A key write changes the lock state at the clock edge that captures it. `unlocked` and the gating of `protWrEn` therefore show the new state from the next cycle. Within a cycle, `protWrEn` follows `protWrReq` combinationally.

The bench drives inputs on the falling edge and checks both outputs one time step later against a model state. That model state is advanced only at the rising edge. Each check therefore sees the state left by earlier key writes, never the one being written. This timing also covers the same-cycle refusal in R9.

// File: rtl/keyLockPkg.sv
package keyLockPkg;

  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_ARMED  = 2'd1,
    LK_OPEN   = 2'd2
  } lockState_t;

  typedef struct packed {
    logic grant;
    logic revoke;
  } lockStrobes_t;

endpackage

// File: rtl/keyLockCtrl.sv
module keyLockCtrl
  import keyLockPkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_FIRST = 8'hCA,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              keyWrStrobe,
  input  logic              keySel,
  input  logic [DATA_W-1:0] keyData,
  output lockStrobes_t      strobes
);

  lockState_t state, nextState;
  logic keyWr, isFirst, isSecond;

  assign keyWr    = keyWrStrobe & keySel;
  assign isFirst  = (keyData == KEY_FIRST);
  assign isSecond = (keyData == KEY_SECOND);

  always_comb begin
    nextState = state;
    strobes   = '0;
    if (keyWr) begin
      unique case (state)
        LK_CLOSED: nextState = isFirst ? LK_ARMED : LK_CLOSED;
        LK_ARMED: begin
          if (isSecond) begin
            nextState     = LK_OPEN;
            strobes.grant = 1'b1;
          end else begin
            nextState = LK_CLOSED;
          end
        end
        LK_OPEN: begin
          nextState      = LK_CLOSED;
          strobes.revoke = 1'b1;
        end
        default: nextState = LK_CLOSED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LK_CLOSED;
    else        state <= nextState;
  end

  // R2: armed plus second key leads to open
  p_second_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (keyWr && state == LK_ARMED && keyData == KEY_SECOND) |=> state == LK_OPEN);

  // R3: armed plus a wrong key falls back to closed
  p_armed_miss_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (keyWr && state == LK_ARMED && keyData != KEY_SECOND) |=> state == LK_CLOSED);

  // R4: any key write while open closes
  p_open_any_key_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (keyWr && state == LK_OPEN) |=> state == LK_CLOSED);

  // R7: no qualified key write, no state change
  p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !keyWr |=> $stable(state));

  // R8: opening always passes through armed
  p_open_via_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_OPEN && $past(state) != LK_OPEN) |-> $past(state) == LK_ARMED);

endmodule

// File: rtl/keyLockGate.sv
module keyLockGate
  import keyLockPkg::*;
#(
  parameter int NUM_PROT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  lockStrobes_t        strobes,
  input  logic [NUM_PROT-1:0] protWrReq,
  output logic [NUM_PROT-1:0] protWrEn,
  output logic                unlocked
);

  logic openQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              openQ <= 1'b0;
    else if (strobes.grant)  openQ <= 1'b1;
    else if (strobes.revoke) openQ <= 1'b0;
  end

  for (genvar lane = 0; lane < NUM_PROT; lane++) begin : g_lane
    assign protWrEn[lane] = protWrReq[lane] & openQ;
  end

  assign unlocked = openQ;

  // R2: a grant strobe opens the gate in the next cycle
  p_grant_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.grant |=> openQ);

  // R4: a revoke strobe shuts the gate in the next cycle
  p_revoke_shuts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.revoke |=> !openQ);

  // R2/R4: strobes are never raised together
  p_strobes_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.grant && strobes.revoke));

endmodule

// File: rtl/keyLock.sv
module keyLock
  import keyLockPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_PROT = 5,
  parameter logic [DATA_W-1:0] KEY_FIRST = 8'hCA,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h53
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                keyWrStrobe,
  input  logic                keySel,
  input  logic [DATA_W-1:0]   keyData,
  input  logic [NUM_PROT-1:0] protWrReq,
  output logic [NUM_PROT-1:0] protWrEn,
  output logic                unlocked
);

  lockStrobes_t strobes;

  keyLockCtrl #(
    .DATA_W(DATA_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .keyWrStrobe(keyWrStrobe), .keySel(keySel),
    .keyData(keyData), .strobes(strobes)
  );

  keyLockGate #(.NUM_PROT(NUM_PROT)) gate_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .protWrReq(protWrReq),
    .protWrEn(protWrEn), .unlocked(unlocked)
  );

  // R5: nothing gets through while closed
  p_closed_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> protWrEn == '0);

  // R6: lanes pass through while open
  p_open_passes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |-> protWrEn == protWrReq);

endmodule

// File: tb/keyLock_tb_top.sv
module keyLock_tb_top;

  localparam int NP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic keyWrStrobe = 1'b0;
  logic keySel = 1'b0;
  logic [7:0] keyData = 8'h00;
  logic [NP-1:0] protWrReq = '0;
  logic [NP-1:0] protWrEn;
  logic unlocked;

  int checks = 0;
  int errors = 0;
  int mState = 0; // 0 closed, 1 armed, 2 open
  bit done = 1'b0;

  always #5 clk = ~clk;

  keyLock #(.NUM_PROT(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .keyWrStrobe(keyWrStrobe), .keySel(keySel),
    .keyData(keyData), .protWrReq(protWrReq), .protWrEn(protWrEn),
    .unlocked(unlocked)
  );

  function automatic int modelNext(int st, bit wr, bit sel, logic [7:0] d);
    if (!(wr && sel)) return st;
    case (st)
      0:       return (d == 8'hCA) ? 1 : 0;
      1:       return (d == 8'h53) ? 2 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [NP-1:0] expEn(int st, logic [NP-1:0] req);
    return (st == 2) ? req : '0;
  endfunction

  task automatic check(string tag);
    logic expU;
    logic [NP-1:0] expE;
    expU = (mState == 2);
    expE = expEn(mState, protWrReq);
    checks++;
    if (unlocked !== expU || protWrEn !== expE) begin
      errors++;
      $display("FAIL %s: unlocked=%0b protWrEn=%b expected unlocked=%0b protWrEn=%b",
               tag, unlocked, protWrEn, expU, expE);
    end
  endtask

  task automatic step(bit wr, bit sel, logic [7:0] d, logic [NP-1:0] req, string tag);
    @(negedge clk);
    keyWrStrobe = wr; keySel = sel; keyData = d; protWrReq = req;
    #1 check(tag);
    @(posedge clk);
    mState = modelNext(mState, wr, sel, d);
  endtask

  task automatic key(logic [7:0] d, string tag);
    step(1'b1, 1'b1, d, '1, tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    protWrReq = '1;
    #1 check("R1");
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;

    // R1: closed after reset, requests blocked (R5)
    step(1'b0, 1'b0, 8'h00, 5'b10101, "R1");
    // R8: lone second key and lone first key do not open
    key(8'h53, "R8");
    key(8'hCA, "R8");
    // R9: request in the cycle of the opening key is refused
    key(8'h53, "R9");
    // R2 / R6: open now, lanes pass
    step(1'b0, 1'b0, 8'h00, 5'b01101, "R2");
    step(1'b0, 1'b0, 8'h00, 5'b10010, "R6");
    // R7: strobe without select, select without strobe
    step(1'b1, 1'b0, 8'hFF, 5'b11111, "R7");
    step(1'b0, 1'b1, 8'hFF, 5'b11111, "R7");
    step(1'b0, 1'b0, 8'h00, 5'b00111, "R7");
    // R4: 0xCA while open closes and does not arm
    key(8'hCA, "R4");
    step(1'b0, 1'b0, 8'h00, 5'b11111, "R4");
    key(8'h53, "R4");
    step(1'b0, 1'b0, 8'h00, 5'b11111, "R4");
    // R3: double first key does not arm for a later second key
    key(8'hCA, "R3");
    key(8'hCA, "R3");
    key(8'h53, "R3");
    step(1'b0, 1'b0, 8'h00, 5'b11111, "R3");
    // R10: gap between keys
    key(8'hCA, "R10");
    step(1'b0, 1'b0, 8'h00, 5'b11111, "R10");
    step(1'b1, 1'b0, 8'h12, 5'b11111, "R10");
    key(8'h53, "R10");
    step(1'b0, 1'b0, 8'h00, 5'b11011, "R10");
    // R4: 0xFF relocks
    key(8'hFF, "R4");
    step(1'b0, 1'b0, 8'h00, 5'b11111, "R5");
    // R4: second key while open relocks
    key(8'hCA, "R2");
    key(8'h53, "R2");
    key(8'h53, "R4");
    step(1'b0, 1'b0, 8'h00, 5'b11111, "R4");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d;
      int pick;
      pick = $urandom % 4;
      d = (pick == 0) ? 8'hCA : (pick == 1) ? 8'h53 : (pick == 2) ? 8'hFF : 8'($urandom);
      step(($urandom % 4) != 0, ($urandom % 3) != 0, d, NP'($urandom),
           (mState == 2) ? "R6" : "R5");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule